// File: doc/BRIEF.md
# Prioritized Restart Interrupt Controller

This block collects five interrupt request lines, each with its own trigger rule, and chooses one request for the processor core to take. The non-maskable line needs a rising edge and a high level that is still present when the line is sampled. One restart line latches on its rising edge. Two restart lines are plain levels. The last line is externally vectored. Requests are sampled only at an instruction boundary that the core signals. The winning request is then presented on a valid/ready output: a restart address, a flag that asks for the return PC to be pushed, and, for the externally vectored line, a flag that asks for an instruction fetch from the bus in place of a fixed address.

The core accepts the presented interrupt by raising `irq_ready_i` while `irq_valid_o` is high. Back-pressure rules: once `irq_valid_o` rises, it stays high and `irq_vec_o`, `ext_fetch_o` and `push_pc_o` hold their values until the cycle with both valid and ready high. No new sampling takes place while a request is presented. `irq_valid_o` falls on the edge that ends the handshake. Accepting any request clears the block's interrupt-enable flip-flop. The core sets and clears that flip-flop with two strobes.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset `irq_valid_o` and `ie_o` are 0, and any latched edge request from before reset is gone.
- R2: When several sources are eligible at one boundary, the winner is, from highest to lowest: non-maskable, edge restart, level restart A, level restart B, external.
- R3: Restart addresses are 0x24 (non-maskable), 0x3C (edge), 0x34 (level A) and 0x2C (level B), each with `ext_fetch_o`=0. The external source presents `irq_vec_o`=0x00 with `ext_fetch_o`=1.
- R4: A rising edge on `src_edge_i` is latched. It stays pending across masking and a cleared enable until its own request is accepted. A level held high after service does not request again.
- R5: Each level source is eligible only while its pin is high on the boundary edge. It requests again on every boundary where the pin is still high.
- R6: The non-maskable source ignores `ie_o` and all mask bits. It needs a rising edge followed by a high level on the boundary edge. A pulse that has gone low before the boundary is dropped. A level held high after service does not request again.
- R7: The other four sources need `ie_o`=1. The three restart sources also need their mask bit at 0. Mask bit 2 belongs to the edge source, bit 1 to level A and bit 0 to level B, and a 1 masks.
- R8: Requests are sampled only on an edge where `boundary_i`=1 and `irq_valid_o`=0. `irq_valid_o` rises on that edge.
- R9: While `irq_valid_o`=1 and `irq_ready_i`=0, the valid, vector and fetch outputs hold steady. The edge with both high ends the handshake and drops `irq_valid_o`.
- R10: On each edge, `ie_o` is updated with this precedence: an accepted handshake clears it, otherwise `ie_clr_i` clears it, otherwise `ie_set_i` sets it.
- R11: `push_pc_o` is 1 exactly when `irq_valid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_nm_i | input | 1 | Non-maskable request line (edge plus level) |
| src_edge_i | input | 1 | Edge-latched restart request |
| src_lvl_a_i | input | 1 | Level restart request A |
| src_lvl_b_i | input | 1 | Level restart request B |
| src_ext_i | input | 1 | Externally vectored request |
| mask_i | input | 3 | Mask bits: [2] edge, [1] level A, [0] level B; 1 masks |
| ie_set_i | input | 1 | Strobe that sets interrupt enable |
| ie_clr_i | input | 1 | Strobe that clears interrupt enable |
| boundary_i | input | 1 | Instruction boundary; sampling point |
| irq_valid_o | output | 1 | An interrupt is presented |
| irq_ready_i | input | 1 | Core accepts the presented interrupt |
| irq_vec_o | output | 8 | Restart address (0 for the external source) |
| ext_fetch_o | output | 1 | Vector must come from an instruction fetched from the bus |
| push_pc_o | output | 1 | Return PC must be pushed |
| ie_o | output | 1 | Interrupt enable state |

## Verification
Level pins are judged on the boundary edge itself. The edge and non-maskable lines need one edge after the pin rises to register the rise, so the bench raises those pins at least one cycle before it pulses `boundary_i`. The presented outputs change on the boundary edge, and the bench reads them at the following falling edge. `ie_o` and the drop of `irq_valid_o` are due on the edge that carries the handshake or the strobe, and the bench reads them half a cycle later. The sweep over level pins, mask bits and enable computes the expected winner and address arithmetically for each of its 64 patterns.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;
  localparam int NSRC   = 5;
  localparam int NMASK  = 3;
  localparam int IDX_NM   = 0;
  localparam int IDX_EDGE = 1;
  localparam int IDX_LA   = 2;
  localparam int IDX_LB   = 3;
  localparam int IDX_EXT  = 4;

  // Restart address is four times an odd code: 9 for the non-maskable
  // source, then 15, 13, 11 for the restart sources in priority order.
  function automatic int restart_addr(input int idx);
    int code;
    code = (idx == IDX_NM) ? 9 : 17 - 2 * idx;
    return code * 4;
  endfunction
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter bit NEED_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic clr,
  input  logic held,
  output logic eligible
);
  logic pin_q;
  logic pend_q;
  logic rise;

  assign rise = pin & ~pin_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q  <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      pin_q <= pin;
      if (rise)
        pend_q <= 1'b1;
      else if (clr)
        pend_q <= 1'b0;
      else if (NEED_LEVEL && !pin && !held)
        pend_q <= 1'b0;
    end
  end

  generate
    if (NEED_LEVEL) begin : g_lvl
      assign eligible = pend_q & pin;
    end else begin : g_edge
      assign eligible = pend_q;
    end
  endgenerate
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_chain
      assign grant[i]  = req[i] & ~seen[i];
      assign seen[i+1] = seen[i] | req[i];
    end
  endgenerate

  assign any = seen[N];
endmodule

// File: rtl/irq_present.sv
module irq_present
  import vec_irq_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boundary,
  input  logic [NSRC-1:0]  grant,
  input  logic             any,
  input  logic             ready,
  output logic             valid,
  output logic [NSRC-1:0]  grant_q,
  output logic [VEC_W-1:0] vec,
  output logic             ext
);
  logic [VEC_W-1:0] vec_n;
  logic             load;

  always_comb begin
    vec_n = '0;
    for (int i = 0; i < NSRC - 1; i++)
      if (grant[i]) vec_n = VEC_W'(restart_addr(i));
  end

  assign load = boundary & ~valid & any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      grant_q <= '0;
      vec     <= '0;
      ext     <= 1'b0;
    end else if (load) begin
      valid   <= 1'b1;
      grant_q <= grant;
      vec     <= vec_n;
      ext     <= grant[IDX_EXT];
    end else if (valid && ready) begin
      valid   <= 1'b0;
      grant_q <= '0;
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vec_irq_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_nm_i,
  input  logic             src_edge_i,
  input  logic             src_lvl_a_i,
  input  logic             src_lvl_b_i,
  input  logic             src_ext_i,
  input  logic [NMASK-1:0] mask_i,
  input  logic             ie_set_i,
  input  logic             ie_clr_i,
  input  logic             boundary_i,
  output logic             irq_valid_o,
  input  logic             irq_ready_i,
  output logic [VEC_W-1:0] irq_vec_o,
  output logic             ext_fetch_o,
  output logic             push_pc_o,
  output logic             ie_o
);
  logic            ie_q;
  logic            accept;
  logic [NSRC-1:0] req;
  logic [NSRC-1:0] grant;
  logic [NSRC-1:0] grant_q;
  logic            any;
  logic            nm_elig;
  logic            edge_elig;
  logic            unused_grant;

  assign accept       = irq_valid_o & irq_ready_i;
  assign unused_grant = &{1'b0, grant_q[NSRC-1:IDX_EDGE+1]};

  always_ff @(posedge clk) begin
    if (!rst_n)          ie_q <= 1'b0;
    else if (accept)     ie_q <= 1'b0;
    else if (ie_clr_i)   ie_q <= 1'b0;
    else if (ie_set_i)   ie_q <= 1'b1;
  end

  irq_edge_latch #(.NEED_LEVEL(1'b1)) u_nm (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (src_nm_i),
    .clr      (accept & grant_q[IDX_NM]),
    .held     (irq_valid_o & grant_q[IDX_NM]),
    .eligible (nm_elig)
  );

  irq_edge_latch #(.NEED_LEVEL(1'b0)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (src_edge_i),
    .clr      (accept & grant_q[IDX_EDGE]),
    .held     (1'b0),
    .eligible (edge_elig)
  );

  assign req[IDX_NM]   = nm_elig;
  assign req[IDX_EDGE] = ie_q & ~mask_i[2] & edge_elig;
  assign req[IDX_LA]   = ie_q & ~mask_i[1] & src_lvl_a_i;
  assign req[IDX_LB]   = ie_q & ~mask_i[0] & src_lvl_b_i;
  assign req[IDX_EXT]  = ie_q & src_ext_i;

  irq_pick #(.N(NSRC)) u_pick (
    .req   (req),
    .grant (grant),
    .any   (any)
  );

  irq_present #(.VEC_W(VEC_W)) u_pres (
    .clk      (clk),
    .rst_n    (rst_n),
    .boundary (boundary_i),
    .grant    (grant),
    .any      (any),
    .ready    (irq_ready_i),
    .valid    (irq_valid_o),
    .grant_q  (grant_q),
    .vec      (irq_vec_o),
    .ext      (ext_fetch_o)
  );

  assign push_pc_o = irq_valid_o;
  assign ie_o      = ie_q;
endmodule

// File: rtl/vec_irq_chk.sv
module vec_irq_chk #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             boundary_i,
  input logic             irq_valid_o,
  input logic             irq_ready_i,
  input logic [VEC_W-1:0] irq_vec_o,
  input logic             ext_fetch_o,
  input logic             push_pc_o,
  input logic             ie_o
);
  assert_rise_needs_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_valid_o && !boundary_i) |=> !irq_valid_o);

  assert_hold_under_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && !irq_ready_i) |=> (irq_valid_o && $stable(irq_vec_o) && $stable(ext_fetch_o)));

  assert_handshake_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && irq_ready_i) |=> !irq_valid_o);

  assert_accept_clears_ie_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && irq_ready_i) |=> !ie_o);

  assert_push_with_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> push_pc_o);

  assert_ext_vector_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && ext_fetch_o) |-> (irq_vec_o == '0));

  assert_fixed_vector_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && !ext_fetch_o) |->
      (irq_vec_o == VEC_W'(8'h24) || irq_vec_o == VEC_W'(8'h3C) ||
       irq_vec_o == VEC_W'(8'h34) || irq_vec_o == VEC_W'(8'h2C)));
endmodule

bind vec_irq_ctrl vec_irq_chk #(.VEC_W(VEC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .boundary_i  (boundary_i),
  .irq_valid_o (irq_valid_o),
  .irq_ready_i (irq_ready_i),
  .irq_vec_o   (irq_vec_o),
  .ext_fetch_o (ext_fetch_o),
  .push_pc_o   (push_pc_o),
  .ie_o        (ie_o)
);

// File: tb/vec_irq_ctrl_test.sv
`timescale 1ns/1ps
module vec_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nm = 0, edg = 0, la = 0, lb = 0, ext = 0;
  logic [2:0] mask = 3'b000;
  logic       ie_set = 0, ie_clr = 0, bnd = 0, ready = 0;
  logic       valid, xf, push, ie;
  logic [7:0] vec;
  int         n_chk = 0, n_bad = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  vec_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_nm_i(nm), .src_edge_i(edg),
    .src_lvl_a_i(la), .src_lvl_b_i(lb), .src_ext_i(ext), .mask_i(mask),
    .ie_set_i(ie_set), .ie_clr_i(ie_clr), .boundary_i(bnd),
    .irq_valid_o(valid), .irq_ready_i(ready), .irq_vec_o(vec),
    .ext_fetch_o(xf), .push_pc_o(push), .ie_o(ie)
  );

  // restart address from priority index: 4 * odd code
  function automatic int addr_of(input int idx);
    return (idx == 0) ? 36 : (17 - 2 * idx) * 4;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expect_irq(input string tag, input bit v, input int a, input bit x);
    chk({tag, " valid"}, int'(valid), int'(v));
    chk({tag, " push R11"}, int'(push), int'(v));
    if (v) begin
      chk({tag, " vector"}, int'(vec), a);
      chk({tag, " fetch"}, int'(xf), int'(x));
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask
  task automatic boundary_pulse();
    bnd = 1; cyc(); bnd = 0;
  endtask
  task automatic accept();
    ready = 1; cyc(); ready = 0;
  endtask
  task automatic set_ie(input bit v);
    if (v) ie_set = 1; else ie_clr = 1;
    cyc(); ie_set = 0; ie_clr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state, and an edge latched before reset is discarded
    cyc(2); rst_n = 1; cyc();
    edg = 1; cyc(); edg = 0; cyc();
    rst_n = 0; cyc(2); rst_n = 1; cyc();
    chk("R1 valid after reset", int'(valid), 0);
    chk("R1 ie after reset", int'(ie), 0);
    set_ie(1);
    chk("R10 ie set", int'(ie), 1);
    boundary_pulse();
    expect_irq("R1 edge latch cleared by reset", 0, 0, 0);

    // R10 precedence: clear beats set
    ie_set = 1; ie_clr = 1; cyc(); ie_set = 0; ie_clr = 0;
    chk("R10 clr over set", int'(ie), 0);

    // R5 R7 R3 R2 sweep over enable, level masks and level/external pins
    for (int p = 0; p < 64; p++) begin
      bit e, ma, mb, pa, pb, px, ea, eb, ex;
      int exp_a;
      e = p[5]; ma = p[4]; mb = p[3]; pa = p[2]; pb = p[1]; px = p[0];
      set_ie(e);
      mask = {1'b0, ma, mb}; la = pa; lb = pb; ext = px;
      cyc();
      boundary_pulse();
      ea = e & ~ma & pa; eb = e & ~mb & pb; ex = e & px;
      exp_a = ea ? addr_of(2) : (eb ? addr_of(3) : 0);
      expect_irq($sformatf("R7 R5 sweep p=%0d", p), ea | eb | ex, exp_a, ~ea & ~eb & ex);
      if (valid) begin
        accept();
        chk("R9 drop after handshake", int'(valid), 0);
        chk("R10 accept clears ie", int'(ie), 0);
      end
      la = 0; lb = 0; ext = 0; mask = 0;
    end

    // R8: a level request waits for the boundary
    set_ie(1); la = 1; cyc(3);
    chk("R8 no sample without boundary", int'(valid), 0);
    boundary_pulse();
    expect_irq("R8 sampled at boundary", 1, addr_of(2), 0);
    // R9 stall with changing inputs, and boundary ignored while valid
    nm = 1; lb = 1; cyc(2); bnd = 1; cyc(); bnd = 0;
    expect_irq("R9 held under stall", 1, addr_of(2), 0);
    accept(); la = 0; lb = 0;
    boundary_pulse();
    expect_irq("R6 edge seen while presenting", 1, addr_of(0), 0);
    nm = 0; cyc();
    expect_irq("R9 held after nm pin drops", 1, addr_of(0), 0);
    accept();
    boundary_pulse();
    expect_irq("R6 nothing after service", 0, 0, 0);

    // R4 edge latch
    set_ie(1); edg = 1; cyc(); edg = 0; cyc(2);
    boundary_pulse();
    expect_irq("R4 latched edge", 1, addr_of(1), 0);
    accept(); set_ie(1);
    boundary_pulse();
    expect_irq("R4 cleared after accept", 0, 0, 0);
    edg = 1; cyc();
    boundary_pulse();
    expect_irq("R4 held-high edge", 1, addr_of(1), 0);
    accept(); set_ie(1);
    boundary_pulse();
    expect_irq("R4 level alone no retrigger", 0, 0, 0);
    edg = 0; cyc();
    mask = 3'b100; edg = 1; cyc(); edg = 0; cyc();
    boundary_pulse();
    expect_irq("R7 edge masked", 0, 0, 0);
    mask = 0; cyc();
    boundary_pulse();
    expect_irq("R4 kept while masked", 1, addr_of(1), 0);
    accept();
    edg = 1; cyc(); edg = 0; cyc();
    boundary_pulse();
    expect_irq("R7 edge needs ie", 0, 0, 0);
    set_ie(1);
    boundary_pulse();
    expect_irq("R4 kept while disabled", 1, addr_of(1), 0);
    ie_set = 1; accept(); ie_set = 0;
    chk("R10 accept over set", int'(ie), 0);

    // R6 non-maskable
    mask = 3'b111; nm = 1; cyc();
    boundary_pulse();
    expect_irq("R6 ignores ie and masks", 1, addr_of(0), 0);
    accept();
    boundary_pulse();
    expect_irq("R6 level alone no retrigger", 0, 0, 0);
    nm = 0; cyc();
    nm = 1; cyc(); nm = 0; cyc();
    boundary_pulse();
    expect_irq("R6 short pulse dropped", 0, 0, 0);
    nm = 1; cyc(); nm = 0; cyc(); nm = 1; cyc(); nm = 0; cyc();
    boundary_pulse();
    expect_irq("R6 dropped pulse stays dropped", 0, 0, 0);
    mask = 0;

    // R2 full priority chain
    set_ie(1); nm = 1; edg = 1; la = 1; lb = 1; ext = 1; cyc();
    boundary_pulse();
    expect_irq("R2 rank 0", 1, addr_of(0), 0);
    accept(); set_ie(1); boundary_pulse();
    expect_irq("R2 rank 1", 1, addr_of(1), 0);
    accept(); set_ie(1); boundary_pulse();
    expect_irq("R2 rank 2", 1, addr_of(2), 0);
    accept(); la = 0; set_ie(1); boundary_pulse();
    expect_irq("R2 rank 3", 1, addr_of(3), 0);
    accept(); lb = 0; set_ie(1); boundary_pulse();
    expect_irq("R2 R3 external last", 1, 0, 1);
    accept();
    nm = 0; edg = 0; ext = 0; cyc();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule